// File: doc/BRIEF.md
# Configuration Register Target on a Two-Wire Serial Bus

This block lets a host on a two-wire serial bus (I2C) reach a bank of configuration registers and a few read-only status bytes. It answers one 7-bit device address out of a set of four. The choice is made by a 2-bit select input. After its address, the host sends a 16-bit register pointer as two bytes. It then streams data bytes. The pointer steps up by one after each byte, in both directions.

Written bytes do not touch the live configuration right away. They collect in a small staging buffer. When the host ends the transfer with a STOP, every staged byte lands in the live registers in the same clock cycle. A repeated START throws the staged bytes away, and so does a fresh START after an abandoned transfer. The bus lines arrive as separate input, output and output-enable signals, which suits an open-drain pad. The configuration bank comes out as a flat parallel vector, and the status bytes come in the same way.

Top module: `cfgi2c_target`

## Requirements
- R1: The target ACKs a write or read address byte whose upper seven bits equal 0x68 plus `dev_sel`, that is 0x68, 0x69, 0x6A or 0x6B.
- R2: An address that does not match gets no ACK. The rest of that transfer has no effect on the registers, and SDA stays released.
- R3: The two bytes after a write address form the register pointer, high byte first.
- R4: Data bytes travel MSB first. Byte n of a block goes to or comes from pointer base+n, and the target holds SDA steady while SCL is high.
- R5: Staged bytes stay out of `cfg_q` until STOP. At STOP, all of them update `cfg_q` in one clock cycle.
- R6: A repeated START before STOP drops all staged bytes, and no configuration register changes.
- R7: After a pointer write, a repeated START with the read bit (address LSB = 1) returns bytes from that pointer upward. A master NACK ends the read and releases SDA.
- R8: Pointers NCFG to NCFG+NSTAT-1 (0x0010 to 0x0013 by default) read `stat_d` byte k at NCFG+k. Writes there are ignored. Pointers beyond that range read 0xFF.
- R9: At most STAGE_DEPTH bytes (8 by default) are staged per write. Later bytes get no ACK and are not staged.
- R10: After reset, every configuration byte is 0x00 and SDA is released.
- R11: A write may end after any complete byte. A STOP after a single data byte commits only that byte, and `cfg_commit` pulses once in the cycle the STOP is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_sel | input | 2 | Picks the device address 0x68 + dev_sel |
| scl_i | input | 1 | SCL as seen on the bus |
| sda_i | input | 1 | SDA as seen on the bus |
| sda_o | output | 1 | SDA drive value, always 0 (open drain) |
| sda_oe | output | 1 | High to pull SDA low |
| stat_d | input | NSTAT*8 | Status bytes; byte k is bits 8k+7:8k |
| cfg_q | output | NCFG*8 | Live configuration bytes; byte j is bits 8j+7:8j |
| cfg_commit | output | 1 | One-cycle pulse when staged bytes are applied |

## Verification
The assertions assume a well-behaved single master. SDA changes only while SCL is low, except to form START and STOP. Each SCL level lasts well beyond the synchronizer delay. The host also never issues a START while the target holds SDA low. Under those conditions, the output enable may switch only after a synchronized SCL fall, and a commit can only follow a STOP.

The bench keeps within these assumptions. Its master model holds every quarter bit for ten system clocks. It moves SDA only in the low phase of SCL, and it releases SDA during acknowledge and read-data slots.

// File: rtl/cfgi2c_pkg.sv
package cfgi2c_pkg;
   localparam int PTR_W = 16;
   localparam logic [6:0] BASE_ADDR7 = 7'h68;

   typedef enum logic [2:0] {
      ST_IDLE, ST_ADDR, ST_PHI, ST_PLO, ST_WDAT, ST_ACK, ST_RDAT, ST_RACK
   } st_t;
endpackage

// File: rtl/cfgi2c_line_sync.sv
module cfgi2c_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_prev,
   output logic sda_prev,
   output logic start_p,
   output logic stop_p,
   output logic scl_rise,
   output logic scl_fall
);
   logic [STAGES-1:0] scl_pipe, sda_pipe;

   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) begin
               scl_pipe <= '1;
               sda_pipe <= '1;
            end else begin
               scl_pipe <= scl_i;
               sda_pipe <= sda_i;
            end
      end else begin : g_many
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) begin
               scl_pipe <= '1;
               sda_pipe <= '1;
            end else begin
               scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
               sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            end
      end
   endgenerate

   assign scl_s = scl_pipe[STAGES-1];
   assign sda_s = sda_pipe[STAGES-1];

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         scl_prev <= 1'b1;
         sda_prev <= 1'b1;
      end else begin
         scl_prev <= scl_s;
         sda_prev <= sda_s;
      end

   assign start_p  = scl_s & scl_prev & sda_prev & ~sda_s;
   assign stop_p   = scl_s & scl_prev & ~sda_prev & sda_s;
   assign scl_rise = scl_s & ~scl_prev;
   assign scl_fall = ~scl_s & scl_prev;
endmodule

// File: rtl/cfgi2c_stage_buf.sv
module cfgi2c_stage_buf #(
   parameter int DEPTH = 8,
   parameter int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear,
   input  logic               push,
   input  logic [7:0]         din,
   output logic [CNT_W-1:0]   count,
   output logic               full,
   output logic [DEPTH*8-1:0] data_flat
);
   logic [7:0] mem [DEPTH];

   assign full = (count == CNT_W'(DEPTH));

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) count <= '0;
      else if (clear) count <= '0;
      else if (push && !full) count <= count + 1'b1;

   always_ff @(posedge clk)
      for (int k = 0; k < DEPTH; k++)
         if (push && !full && count == CNT_W'(k)) mem[k] <= din;

   generate
      for (genvar k = 0; k < DEPTH; k++) begin : g_flat
         assign data_flat[k*8 +: 8] = mem[k];
      end
   endgenerate
endmodule

// File: rtl/cfgi2c_regbank.sv
module cfgi2c_regbank
   import cfgi2c_pkg::*;
#(
   parameter int NCFG  = 16,
   parameter int NSTAT = 4,
   parameter int DEPTH = 8,
   parameter int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               commit,
   input  logic [PTR_W-1:0]   base,
   input  logic [CNT_W-1:0]   count,
   input  logic [DEPTH*8-1:0] stage_flat,
   input  logic [PTR_W-1:0]   rd_ptr,
   input  logic [NSTAT*8-1:0] stat_d,
   output logic [NCFG*8-1:0]  cfg_flat,
   output logic [7:0]         rd_byte
);
   logic [7:0] cfg_r [NCFG];

   generate
      for (genvar j = 0; j < NCFG; j++) begin : g_reg
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) cfg_r[j] <= 8'h00;
            else if (commit)
               for (int k = 0; k < DEPTH; k++)
                  if (CNT_W'(k) < count && base + PTR_W'(k) == PTR_W'(j))
                     cfg_r[j] <= stage_flat[k*8 +: 8];
         assign cfg_flat[j*8 +: 8] = cfg_r[j];
      end
   endgenerate

   always_comb begin
      rd_byte = 8'hFF;
      for (int k = 0; k < NCFG; k++)
         if (rd_ptr == PTR_W'(k)) rd_byte = cfg_r[k];
      for (int k = 0; k < NSTAT; k++)
         if (rd_ptr == PTR_W'(NCFG + k)) rd_byte = stat_d[k*8 +: 8];
   end
endmodule

// File: rtl/cfgi2c_target.sv
module cfgi2c_target
   import cfgi2c_pkg::*;
#(
   parameter int NCFG        = 16,
   parameter int NSTAT       = 4,
   parameter int STAGE_DEPTH = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [1:0]         dev_sel,
   input  logic               scl_i,
   input  logic               sda_i,
   output logic               sda_o,
   output logic               sda_oe,
   input  logic [NSTAT*8-1:0] stat_d,
   output logic [NCFG*8-1:0]  cfg_q,
   output logic               cfg_commit
);
   localparam int CNT_W = $clog2(STAGE_DEPTH + 1);

   generate
      if (STAGE_DEPTH < 2) begin : g_bad_depth
         $error("STAGE_DEPTH must be at least 2");
      end
      if (NCFG < 1 || NSTAT < 1 || NCFG + NSTAT > 65536) begin : g_bad_map
         $error("register map does not fit the 16-bit pointer");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic scl_s, sda_s, scl_prev, sda_prev, start_p, stop_p, scl_rise, scl_fall;
   st_t              st_q, ret_q;
   logic [2:0]       bitcnt_q;
   logic [7:0]       shreg_q, rd_byte;
   logic             got8_q, ack_q, mack_q, is_idle;
   logic [PTR_W-1:0] ptr_q, base_q;
   logic [CNT_W-1:0] stage_cnt;
   logic             stage_full, stage_push;
   logic [STAGE_DEPTH*8-1:0] stage_flat;
   logic [6:0]       my_addr;

   cfgi2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_s(scl_s), .sda_s(sda_s), .scl_prev(scl_prev), .sda_prev(sda_prev),
      .start_p(start_p), .stop_p(stop_p), .scl_rise(scl_rise), .scl_fall(scl_fall));

   assign my_addr    = BASE_ADDR7 + {5'b0, dev_sel};
   assign stage_push = (st_q == ST_WDAT) && scl_fall && got8_q && !start_p && !stop_p;
   assign cfg_commit = stop_p && (stage_cnt != '0);
   assign is_idle    = (st_q == ST_IDLE);

   cfgi2c_stage_buf #(.DEPTH(STAGE_DEPTH), .CNT_W(CNT_W)) u_stage (
      .clk(clk), .rst_n(rst_n), .clear(start_p | stop_p), .push(stage_push),
      .din(shreg_q), .count(stage_cnt), .full(stage_full), .data_flat(stage_flat));

   cfgi2c_regbank #(.NCFG(NCFG), .NSTAT(NSTAT), .DEPTH(STAGE_DEPTH), .CNT_W(CNT_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .commit(cfg_commit), .base(base_q), .count(stage_cnt),
      .stage_flat(stage_flat), .rd_ptr(ptr_q), .stat_d(stat_d),
      .cfg_flat(cfg_q), .rd_byte(rd_byte));

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         st_q <= ST_IDLE;  ret_q <= ST_IDLE;  bitcnt_q <= '0;  shreg_q <= '0;
         got8_q <= 1'b0;  ack_q <= 1'b0;  mack_q <= 1'b0;
         ptr_q <= '0;  base_q <= '0;
      end else if (start_p) begin
         st_q <= ST_ADDR;  bitcnt_q <= '0;  got8_q <= 1'b0;  ack_q <= 1'b0;
      end else if (stop_p) begin
         st_q <= ST_IDLE;  ack_q <= 1'b0;  got8_q <= 1'b0;
      end else begin
         unique case (st_q)
            ST_ADDR, ST_PHI, ST_PLO, ST_WDAT: begin
               if (scl_rise) begin
                  shreg_q  <= {shreg_q[6:0], sda_s};
                  bitcnt_q <= bitcnt_q + 3'd1;
                  got8_q   <= (bitcnt_q == 3'd7);
               end else if (scl_fall && got8_q) begin
                  got8_q   <= 1'b0;
                  bitcnt_q <= '0;
                  st_q     <= ST_ACK;
                  ack_q    <= 1'b1;
                  unique case (st_q)
                     ST_ADDR: begin
                        if (shreg_q[7:1] != my_addr) begin
                           st_q  <= ST_IDLE;
                           ack_q <= 1'b0;
                        end
                        ret_q <= shreg_q[0] ? ST_RDAT : ST_PHI;
                     end
                     ST_PHI: begin
                        ptr_q[15:8] <= shreg_q;
                        ret_q       <= ST_PLO;
                     end
                     ST_PLO: begin
                        ptr_q[7:0] <= shreg_q;
                        base_q     <= {ptr_q[15:8], shreg_q};
                        ret_q      <= ST_WDAT;
                     end
                     default: begin
                        ret_q <= ST_WDAT;
                        ack_q <= !stage_full;
                        if (!stage_full) ptr_q <= ptr_q + 1'b1;
                     end
                  endcase
               end
            end
            ST_ACK:
               if (scl_fall) begin
                  ack_q <= 1'b0;
                  st_q  <= ret_q;
                  if (ret_q == ST_RDAT) begin
                     shreg_q <= rd_byte;
                     ptr_q   <= ptr_q + 1'b1;
                  end
               end
            ST_RDAT:
               if (scl_fall) begin
                  if (bitcnt_q == 3'd7) st_q <= ST_RACK;
                  else begin
                     shreg_q  <= {shreg_q[6:0], 1'b1};
                     bitcnt_q <= bitcnt_q + 3'd1;
                  end
               end
            ST_RACK: begin
               if (scl_rise) mack_q <= !sda_s;
               if (scl_fall) begin
                  if (mack_q) begin
                     shreg_q  <= rd_byte;
                     ptr_q    <= ptr_q + 1'b1;
                     bitcnt_q <= '0;
                     st_q     <= ST_RDAT;
                  end else st_q <= ST_IDLE;
               end
            end
            default: ;
         endcase
      end

   assign sda_o  = 1'b0;
   assign sda_oe = ((st_q == ST_ACK) && ack_q) || ((st_q == ST_RDAT) && !shreg_q[7]);
endmodule

// File: rtl/cfgi2c_target_chk.sv
module cfgi2c_target_chk #(
   parameter int NCFG  = 16,
   parameter int DEPTH = 8,
   parameter int CNT_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scl_s,
   input logic              sda_s,
   input logic              sda_oe,
   input logic              is_idle,
   input logic [NCFG*8-1:0] cfg_q,
   input logic              cfg_commit,
   input logic [CNT_W-1:0]  stage_cnt
);
   p_cfg_moves_on_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cfg_q) |-> $past(cfg_commit));

   p_commit_at_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_commit |-> (scl_s && sda_s && $past(scl_s) && !$past(sda_s)));

   p_oe_steady_scl_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_s && $past(scl_s)) |-> $stable(sda_oe));

   p_idle_released_r2: assert property (@(posedge clk) disable iff (!rst_n)
      is_idle |-> !sda_oe);

   p_stage_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      stage_cnt <= CNT_W'(DEPTH));

   p_stage_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (stage_cnt != $past(stage_cnt)) |-> (stage_cnt == $past(stage_cnt) + 1'b1 || stage_cnt == '0));
endmodule

bind cfgi2c_target cfgi2c_target_chk #(.NCFG(NCFG), .DEPTH(STAGE_DEPTH), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s), .sda_oe(sda_oe),
   .is_idle(is_idle), .cfg_q(cfg_q), .cfg_commit(cfg_commit), .stage_cnt(stage_cnt));

// File: tb/cfgi2c_target_tb.sv
module cfgi2c_target_tb;
   localparam int NCFG = 16, NSTAT = 4, DEPTH = 8, Q = 10;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [1:0] dev_sel = 2'd0;
   logic scl_m = 1'b1, sda_m = 1'b1;
   logic sda_o, sda_oe, cfg_commit, sda_line;
   logic [NSTAT*8-1:0] stat_d = 32'hD4C3B2A1;
   logic [NCFG*8-1:0]  cfg_q, cfg_prev;
   int total = 0, bad = 0, chg = 0;
   bit done = 0;

   always #2 clk = ~clk;
   assign sda_line = sda_m & ~(sda_oe & ~sda_o);

   cfgi2c_target #(.NCFG(NCFG), .NSTAT(NSTAT), .STAGE_DEPTH(DEPTH)) u_dut (
      .clk(clk), .rst_n(rst_n), .dev_sel(dev_sel), .scl_i(scl_m), .sda_i(sda_line),
      .sda_o(sda_o), .sda_oe(sda_oe), .stat_d(stat_d), .cfg_q(cfg_q), .cfg_commit(cfg_commit));

   always @(posedge clk) begin
      if (rst_n && cfg_q !== cfg_prev) chg = chg + 1;
      cfg_prev = cfg_q;
   end

   function automatic logic [7:0] cb(int j);
      return cfg_q[j*8 +: 8];
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wq();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
   endtask

   task automatic send(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
      end
      sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); ack = !sda_line; wq(); scl_m = 1'b0; wq();
   endtask

   task automatic recv(input logic mack, output logic [7:0] b);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         wq(); scl_m = 1'b1; wq(); b[i] = sda_line; wq(); scl_m = 1'b0;
      end
      sda_m = !mack; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq(); sda_m = 1'b1;
   endtask

   // address, pointer, then n data bytes; leaves the bus without STOP
   task automatic wr_open(logic [15:0] ptr, int n, logic [7:0] d [16]);
      logic a;
      bus_start();
      send({7'h68 + {5'b0, dev_sel}, 1'b0}, a);
      send(ptr[15:8], a);
      send(ptr[7:0], a);
      for (int i = 0; i < n; i++) send(d[i], a);
   endtask

   task automatic rd_seq(logic [15:0] ptr, int n, output logic [7:0] r [16]);
      logic a;
      logic [7:0] d [16];
      d = '{default: 8'h00};
      wr_open(ptr, 0, d);
      bus_start();
      send({7'h68 + {5'b0, dev_sel}, 1'b1}, a);
      for (int i = 0; i < n; i++) recv(i != n - 1, r[i]);
      bus_stop();
   endtask

   task automatic t_reset();
      chk("R10 cfg after reset", cfg_q[31:0], 32'h0);
      chk("R10 cfg high after reset", cfg_q[127:96], 32'h0);
      chk("R10 sda released", sda_oe, 1'b0);
   endtask

   task automatic t_addr();
      logic a;
      for (int s = 0; s < 4; s++) begin
         dev_sel = 2'(s);
         bus_start(); send({7'h68 + 7'(s), 1'b0}, a); bus_stop();
         chk("R1 own address ack", a, 1'b1);
      end
      dev_sel = 2'd0;
   endtask

   task automatic t_wrong();
      logic a;
      bus_start(); send({7'h6A, 1'b0}, a);
      chk("R2 foreign address nack", a, 1'b0);
      send(8'h00, a); send(8'h00, a); send(8'h55, a);
      chk("R2 no ack after foreign", a, 1'b0);
      bus_stop();
      chk("R2 cfg untouched", cb(0), 8'h00);
      chk("R2 sda released", sda_oe, 1'b0);
   endtask

   task automatic t_write_commit();
      logic [7:0] d [16];
      d = '{default: 8'h00};
      d[0] = 8'hA1; d[1] = 8'hB2; d[2] = 8'hC3;
      wr_open(16'h0002, 3, d);
      chk("R5 not visible before stop", {cb(2), cb(3), cb(4)}, 24'h0);
      chg = 0;
      bus_stop();
      chk("R4 byte at base", cb(2), 8'hA1);
      chk("R4 byte at base+1", cb(3), 8'hB2);
      chk("R4 byte at base+2", cb(4), 8'hC3);
      chk("R5 single update cycle", chg, 1);
      d[0] = 8'h77;
      wr_open(16'h0105, 1, d); bus_stop();
      chk("R3 high pointer byte honoured", cb(5), 8'h00);
   endtask

   task automatic t_read();
      logic [7:0] r [16];
      rd_seq(16'h0002, 3, r);
      chk("R7 read byte 0", r[0], 8'hA1);
      chk("R7 read byte 1", r[1], 8'hB2);
      chk("R7 read byte 2", r[2], 8'hC3);
      chk("R7 sda released after nack", sda_oe, 1'b0);
   endtask

   task automatic t_rstart();
      logic [7:0] d [16];
      d = '{default: 8'h00};
      d[0] = 8'h5A;
      chg = 0;
      wr_open(16'h0008, 1, d);
      bus_start();
      bus_stop();
      chk("R6 discard on repeated start", cb(8), 8'h00);
      chk("R6 no change at all", chg, 0);
   endtask

   task automatic t_status();
      logic [7:0] r [16];
      logic [7:0] d [16];
      d = '{default: 8'h00};
      rd_seq(16'h0010, 2, r);
      chk("R8 status byte 0", r[0], 8'hA1);
      chk("R8 status byte 1", r[1], 8'hB2);
      d[0] = 8'h00;
      wr_open(16'h0011, 1, d); bus_stop();
      rd_seq(16'h0011, 1, r);
      chk("R8 status write ignored", r[0], 8'hB2);
      rd_seq(16'h0040, 1, r);
      chk("R8 unmapped reads FF", r[0], 8'hFF);
   endtask

   task automatic t_single();
      logic [7:0] d [16];
      d = '{default: 8'h00};
      d[0] = 8'h3C;
      wr_open(16'h000F, 1, d); bus_stop();
      chk("R11 single byte committed", cb(15), 8'h3C);
      chk("R11 neighbour untouched", cb(14), 8'h00);
   endtask

   task automatic t_overflow();
      logic a;
      logic [7:0] d [16];
      bus_start();
      send({7'h68, 1'b0}, a); send(8'h00, a); send(8'h00, a);
      for (int i = 0; i < 10; i++) begin
         d[i] = 8'h10 + 8'(i);
         send(d[i], a);
         chk(i < DEPTH ? "R9 ack within depth" : "R9 nack beyond depth", a, i < DEPTH);
      end
      bus_stop();
      for (int i = 0; i < DEPTH; i++) chk("R9 staged byte committed", cb(i), 8'h10 + 8'(i));
      chk("R9 byte 9 not staged", cb(8), 8'h00);
      chk("R9 byte 10 not staged", cb(9), 8'h00);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      t_reset();
      t_addr();
      t_wrong();
      t_write_commit();
      t_read();
      t_rstart();
      t_status();
      t_single();
      t_overflow();
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog run did not complete actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule